// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the scan timing for a TFT panel. It divides the system clock by a programmable integer to make a pixel-advance strobe and a pixel clock output. From that strobe it runs a horizontal and a vertical position counter. Each line is laid out as sync, back porch, active pixels and front porch, and each frame uses the same order counted in lines. From the two counters it derives hsync, vsync, data-enable, the in-picture pixel coordinates and a frame-done pulse.

The geometry comes from three 32-bit configuration words. Several fields are split into low and high parts across the words. The words are captured only at a frame boundary or while the block is disabled, so a write made during a frame never tears it. The polarity of the syncs and of the pixel clock can be inverted, and the syncs can be moved to the falling half of the pixel clock. Clearing `enable` parks the scan at the first pixel of vsync, and setting it again starts a fresh frame from there.

Top module: `lcd_raster_timer`

## Requirements
- R1: `pix_ce` is high for one clock in every D clocks, where D is `div_cfg`. A `div_cfg` value of 0 or 1 acts as D = 2.
- R2: A line is H = (hs+1) + (hbp+1) + 16*(ppl+1) + (hfp+1) pixels, in the order sync, back porch, active, front porch. The fields are placed as follows. hs is `{tcfg2[30:27], tcfg0[15:10]}`. hbp is `{tcfg2[5:4], tcfg0[31:24]}`. hfp is `{tcfg2[1:0], tcfg0[23:16]}`. ppl is `{tcfg0[3], tcfg0[9:4]}`.
- R3: A frame is V = (vs+1) + vbp + (lpp+1) + vfp lines, in the order sync, back porch, active, front porch. vs is `tcfg1[15:10]`, vbp is `tcfg1[31:24]`, vfp is `tcfg1[23:16]` and lpp is `{tcfg2[26], tcfg1[9:0]}`.
- R4: `de` is high only when both counters are in their active regions. `pix_x` and `pix_y` count from 0 at the first active pixel and line. Over one frame, `de` is high for D*16*(ppl+1)*(lpp+1) clocks.
- R5: When `tcfg2[21]` is clear, `hsync` is active-high, and when it is set, `hsync` is active-low. `tcfg2[20]` does the same for `vsync`.
- R6: Within each pixel period, `pclk` is high for the first ceil(D/2) clocks and rises together with the pixel advance. Setting `tcfg2[22]` inverts `pclk`.
- R7: When `tcfg2[25]` = 1 and `tcfg2[24]` = 0, the syncs change at the falling edge of the pixel clock, half a pixel after the counters move. With any other setting of these two bits, the syncs change together with the counters.
- R8: `frame_done` is a one-clock pulse. It appears in the first clock of each new frame, once the last pixel of the final line has been left, so consecutive pulses are D*H*V clocks apart.
- R9: While `enable` is low, `pix_ce`, `de` and `frame_done` are low, and the syncs and `pclk` sit at their inactive levels. On the first clock with `enable` high, hsync and vsync are both active, and the first `frame_done` follows D*H*V clocks later.
- R10: The configuration words and `div_cfg` are sampled only while `enable` is low or at the frame wrap. A write made during a frame takes effect from the next frame.
- R11: A vertical back porch and front porch of zero lines are legal and simply drop those phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the scan; low parks it at frame start |
| div_cfg | input | 8 | Pixel clock divisor |
| tcfg0 | input | 32 | Horizontal geometry word |
| tcfg1 | input | 32 | Vertical geometry word |
| tcfg2 | input | 32 | High field bits, polarity and sync edge word |
| pix_ce | output | 1 | One-clock pixel advance strobe |
| pclk | output | 1 | Pixel clock output |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | XW | Column inside the active area |
| pix_y | output | YW | Line inside the active area |
| frame_done | output | 1 | Start-of-frame pulse after a completed frame |

## Verification
The counters, `pix_ce`, `pclk` and `de` move on the clock edge after the divider reaches its terminal count. `frame_done` registers one edge after the wrap, so it marks the first clock of the new frame. In the late-sync mode the syncs trail the counters by ceil(D/2) clocks. Because every result lands on a known edge, the checks sample on the falling clock edge and accumulate counts over windows that run from one `frame_done` to the next. The two responses that follow `enable` combinationally are sampled one nanosecond after the input changes.

// File: rtl/tg_pkg.sv
`timescale 1ns/1ps
// Shared widths and types for the raster timing generator.
// Assumes lines and frames fit in CW-bit position counters.
package tg_pkg;
    localparam int CW = 13;   // position counter width (5120 px / 2622 lines max)
    localparam int DW = 8;    // divisor width

    // Phase boundaries along one axis, all measured from position 0.
    typedef struct packed {
        logic [CW-1:0] sync_end;
        logic [CW-1:0] act_beg;
        logic [CW-1:0] act_end;
        logic [CW-1:0] total;
    } axis_bnd_t;

    // Divisor and output-shaping options.
    typedef struct packed {
        logic [DW-1:0] div;
        logic          inv_hs;
        logic          inv_vs;
        logic          inv_pc;
        logic          edge_sel;
        logic          edge_rise;
    } ctl_cfg_t;
endpackage

// File: rtl/tg_cfg_latch.sv
`timescale 1ns/1ps
// Decodes the three geometry words into per-axis phase boundaries and
// holds them, along with the divisor and the polarity options, between
// load strobes. Assumes load is high while disabled and at frame wrap.
module tg_cfg_latch
    import tg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] div_in,
    input  logic [31:0]   w0,
    input  logic [31:0]   w1,
    input  logic [31:0]   w2,
    output axis_bnd_t     hbnd,
    output axis_bnd_t     vbnd,
    output ctl_cfg_t      ctl
);
    localparam logic [CW-1:0] ONE    = CW'(1);
    localparam logic [DW-1:0] MINDIV = DW'(2);

    logic [CW-1:0] h_sw, h_bp, h_fp, h_units, h_px;
    logic [CW-1:0] v_sw, v_bp, v_fp, v_ln;
    axis_bnd_t     hbnd_d, vbnd_d;
    ctl_cfg_t      ctl_d;

    // Field extraction: horizontal counts are stored minus one.
    always_comb begin
        h_sw    = CW'({w2[30:27], w0[15:10]}) + ONE;
        h_bp    = CW'({w2[5:4],   w0[31:24]}) + ONE;
        h_fp    = CW'({w2[1:0],   w0[23:16]}) + ONE;
        h_units = CW'({w0[3],     w0[9:4]})   + ONE;
        h_px    = {h_units[CW-5:0], 4'b0000};
        v_sw    = CW'(w1[15:10]) + ONE;
        v_bp    = CW'(w1[31:24]);
        v_fp    = CW'(w1[23:16]);
        v_ln    = CW'({w2[26], w1[9:0]}) + ONE;
    end

    // Cumulative phase boundaries for both axes.
    always_comb begin
        hbnd_d.sync_end = h_sw;
        hbnd_d.act_beg  = h_sw + h_bp;
        hbnd_d.act_end  = h_sw + h_bp + h_px;
        hbnd_d.total    = h_sw + h_bp + h_px + h_fp;
        vbnd_d.sync_end = v_sw;
        vbnd_d.act_beg  = v_sw + v_bp;
        vbnd_d.act_end  = v_sw + v_bp + v_ln;
        vbnd_d.total    = v_sw + v_bp + v_ln + v_fp;
    end

    // Divisor clamp and option bits.
    always_comb begin
        ctl_d.div       = (div_in < MINDIV) ? MINDIV : div_in;
        ctl_d.inv_hs    = w2[21];
        ctl_d.inv_vs    = w2[20];
        ctl_d.inv_pc    = w2[22];
        ctl_d.edge_sel  = w2[25];
        ctl_d.edge_rise = w2[24];
    end

    // Capture on the load strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hbnd <= '0;
            vbnd <= '0;
            ctl  <= '{div: MINDIV, default: 1'b0};
        end else if (load) begin
            hbnd <= hbnd_d;
            vbnd <= vbnd_d;
            ctl  <= ctl_d;
        end
    end
endmodule

// File: rtl/tg_pixdiv.sv
`timescale 1ns/1ps
// Divides the system clock into a pixel-advance strobe and a pixel clock
// whose first ceil(D/2) clocks are high. Assumes div >= 2.
module tg_pixdiv #(
    parameter int DW = tg_pkg::DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [DW-1:0] div,
    output logic          pix_ce,
    output logic          fall_ce,
    output logic          pclk_raw
);
    localparam logic [DW-1:0] ONE = DW'(1);

    logic [DW-1:0] dcnt;
    logic [DW:0]   half_w;
    logic [DW-1:0] half;

    // High-phase length of the pixel clock.
    always_comb begin
        half_w = ({1'b0, div} + (DW+1)'(1)) >> 1;
        half   = half_w[DW-1:0];
    end

    // Clock counter within one pixel period.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            dcnt <= '0;
        else if (dcnt == div - ONE)
            dcnt <= '0;
        else
            dcnt <= dcnt + ONE;
    end

    // Strobes and pixel clock level.
    always_comb begin
        pix_ce   = enable && (dcnt == div - ONE);
        fall_ce  = enable && (dcnt == half - ONE);
        pclk_raw = enable && (dcnt < half);
    end

    // R1
    ce_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ce |=> !pix_ce);

    // R6
    pclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ce |=> (pclk_raw || !enable));
endmodule

// File: rtl/tg_axis.sv
`timescale 1ns/1ps
// One scan axis: a position counter that wraps at the programmed total,
// plus decode of the sync and active phases. Assumes bnd is ordered
// sync_end <= act_beg <= act_end <= total and total >= 1.
module tg_axis
    import tg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  axis_bnd_t     bnd,
    output logic [CW-1:0] pos,
    output logic [CW-1:0] offs,
    output logic          last,
    output logic          in_sync,
    output logic          in_act
);
    localparam logic [CW-1:0] ONE = CW'(1);

    // Position advance and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            pos <= '0;
        else if (step)
            pos <= last ? '0 : pos + ONE;
    end

    // Phase decode and offset into the active region.
    always_comb begin
        last    = (pos == bnd.total - ONE);
        in_sync = (pos < bnd.sync_end);
        in_act  = (pos >= bnd.act_beg) && (pos < bnd.act_end);
        offs    = in_act ? (pos - bnd.act_beg) : '0;
    end

    // R9
    pos_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pos == '0));

    // R2
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (pos < bnd.total));
endmodule

// File: rtl/lcd_raster_timer.sv
`timescale 1ns/1ps
// Raster timing generator top: configuration capture, pixel divider,
// horizontal and vertical scan counters, and output shaping for the
// syncs, data enable, pixel clock and frame-done pulse.
// Assumes the geometry words describe a legal panel.
module lcd_raster_timer
    import tg_pkg::*;
#(
    parameter int XW = 11,
    parameter int YW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [7:0]    div_cfg,
    input  logic [31:0]   tcfg0,
    input  logic [31:0]   tcfg1,
    input  logic [31:0]   tcfg2,
    output logic          pix_ce,
    output logic          pclk,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [XW-1:0] pix_x,
    output logic [YW-1:0] pix_y,
    output logic          frame_done
);
    localparam int NAX = 2;   // 0: horizontal, 1: vertical

    axis_bnd_t     hbnd, vbnd;
    ctl_cfg_t      ctl;
    logic          load, fall_ce, pclk_raw;
    axis_bnd_t     ax_bnd  [NAX];
    logic          ax_step [NAX];
    logic [CW-1:0] ax_pos  [NAX];
    logic [CW-1:0] ax_offs [NAX];
    logic          ax_last [NAX];
    logic          ax_sync [NAX];
    logic          ax_act  [NAX];
    logic          hs_raw, vs_raw, hs_hold, vs_hold, late_sync;

    // Configuration is taken while parked or on the last pixel of a frame.
    assign load = !enable || (pix_ce && ax_last[0] && ax_last[1]);

    tg_cfg_latch u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .div_in (div_cfg),
        .w0     (tcfg0),
        .w1     (tcfg1),
        .w2     (tcfg2),
        .hbnd   (hbnd),
        .vbnd   (vbnd),
        .ctl    (ctl)
    );

    tg_pixdiv #(.DW(DW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .div      (ctl.div),
        .pix_ce   (pix_ce),
        .fall_ce  (fall_ce),
        .pclk_raw (pclk_raw)
    );

    // Axis wiring: vertical steps on the last pixel of each line.
    always_comb begin
        ax_bnd[0]  = hbnd;
        ax_bnd[1]  = vbnd;
        ax_step[0] = pix_ce;
        ax_step[1] = pix_ce && ax_last[0];
    end

    for (genvar g = 0; g < NAX; g++) begin : g_axis
        tg_axis u_axis (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (!enable),
            .step    (ax_step[g]),
            .bnd     (ax_bnd[g]),
            .pos     (ax_pos[g]),
            .offs    (ax_offs[g]),
            .last    (ax_last[g]),
            .in_sync (ax_sync[g]),
            .in_act  (ax_act[g])
        );
    end

    // Raw sync levels and late-edge selection.
    always_comb begin
        hs_raw    = enable && ax_sync[0];
        vs_raw    = enable && ax_sync[1];
        late_sync = ctl.edge_sel && !ctl.edge_rise;
    end

    // Sync samples taken on the falling half of the pixel clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            hs_hold <= 1'b0;
            vs_hold <= 1'b0;
        end else if (fall_ce) begin
            hs_hold <= hs_raw;
            vs_hold <= vs_raw;
        end
    end

    // Output polarity, data enable and coordinates.
    always_comb begin
        hsync = (late_sync ? hs_hold : hs_raw) ^ ctl.inv_hs;
        vsync = (late_sync ? vs_hold : vs_raw) ^ ctl.inv_vs;
        pclk  = pclk_raw ^ ctl.inv_pc;
        de    = enable && ax_act[0] && ax_act[1];
        pix_x = XW'(ax_offs[0]);
        pix_y = YW'(ax_offs[1]);
    end

    // Frame-done pulse registered at the frame wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_done <= 1'b0;
        else
            frame_done <= pix_ce && ax_last[0] && ax_last[1];
    end

    // R8
    fd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R4
    de_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (!ax_sync[0] && !ax_sync[1]));

    // R8
    fd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (ax_pos[0] == '0 && ax_pos[1] == '0));
endmodule

// File: tb/test_lcd_raster_timer.sv
`timescale 1ns/1ps
module test_lcd_raster_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [7:0]  div_cfg = '0;
    logic [31:0] tcfg0 = '0, tcfg1 = '0, tcfg2 = '0;
    logic        pix_ce, pclk, hsync, vsync, de, frame_done;
    logic [10:0] pix_x, pix_y;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    lcd_raster_timer i_lcd_raster_timer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_cfg(div_cfg),
        .tcfg0(tcfg0), .tcfg1(tcfg1), .tcfg2(tcfg2), .pix_ce(pix_ce),
        .pclk(pclk), .hsync(hsync), .vsync(vsync), .de(de),
        .pix_x(pix_x), .pix_y(pix_y), .frame_done(frame_done)
    );

    // Fields: div, hs, hbp, hfp, ppl, vs, vbp, vfp, lpp, inv_hs, inv_vs, inv_pc
    localparam logic [11:0] VEC [5][12] = '{
        '{12'd2, 12'd0,  12'd1,   12'd2,   12'd0,  12'd0, 12'd1, 12'd1, 12'd2, 12'd0, 12'd0, 12'd0},
        '{12'd3, 12'd3,  12'd0,   12'd0,   12'd1,  12'd1, 12'd0, 12'd0, 12'd3, 12'd1, 12'd1, 12'd1},
        '{12'd1, 12'd1,  12'd2,   12'd1,   12'd0,  12'd2, 12'd2, 12'd1, 12'd1, 12'd1, 12'd0, 12'd0},
        '{12'd5, 12'd2,  12'd1,   12'd1,   12'd0,  12'd0, 12'd1, 12'd2, 12'd0, 12'd0, 12'd1, 12'd1},
        '{12'd2, 12'd64, 12'd256, 12'd300, 12'd64, 12'd0, 12'd0, 12'd0, 12'd1, 12'd0, 12'd0, 12'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_cfg(input int i, input logic esel, input logic erise,
                             input logic [11:0] hfp_over);
        logic [11:0] hs, hbp, hfp, ppl, vs, vbp, vfp, lpp;
        hs = VEC[i][1]; hbp = VEC[i][2]; hfp = (hfp_over != 0) ? hfp_over : VEC[i][3];
        ppl = VEC[i][4]; vs = VEC[i][5]; vbp = VEC[i][6]; vfp = VEC[i][7]; lpp = VEC[i][8];
        div_cfg = VEC[i][0][7:0];
        tcfg0 = {hbp[7:0], hfp[7:0], hs[5:0], ppl[5:0], ppl[6], 3'b000};
        tcfg1 = {vbp[7:0], vfp[7:0], vs[5:0], lpp[9:0]};
        tcfg2 = {1'b0, hs[9:6], lpp[10], esel, erise, 1'b0, VEC[i][11][0],
                 VEC[i][9][0], VEC[i][10][0], 14'd0, hbp[9:8], 2'b00, hfp[9:8]};
    endtask

    task automatic restart(input int i, input logic esel, input logic erise);
        @(negedge clk);
        enable = 1'b0;
        drive_cfg(i, esel, erise, 12'd0);
        repeat (2) @(negedge clk);
        enable = 1'b1;
    endtask

    function automatic int div_of(input int i);
        return (VEC[i][0] < 2) ? 2 : int'(VEC[i][0]);
    endfunction
    function automatic int htot(input int i);
        return VEC[i][1] + 1 + VEC[i][2] + 1 + 16 * (VEC[i][4] + 1) + VEC[i][3] + 1;
    endfunction
    function automatic int vtot(input int i);
        return VEC[i][5] + 1 + VEC[i][6] + VEC[i][8] + 1 + VEC[i][7];
    endfunction

    // Counts one frame, from a frame_done cycle up to the next one.
    task automatic measure(input logic ihs, input logic ivs, output int clks,
                           output int hsn, output int vsn, output int den,
                           output int pcn, output int mx, output int my);
        clks = 0; hsn = 0; vsn = 0; den = 0; pcn = 0; mx = 0; my = 0;
        while (!frame_done) @(negedge clk);
        do begin
            clks++;
            if (hsync == !ihs) hsn++;
            if (vsync == !ivs) vsn++;
            if (pclk) pcn++;
            if (de) begin
                den++;
                if (int'(pix_x) > mx) mx = int'(pix_x);
                if (int'(pix_y) > my) my = int'(pix_y);
            end
            @(negedge clk);
        end while (!frame_done);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int clks, hsn, vsn, den, pcn, mx, my, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset and parked state
        chk("R9 reset hsync", hsync, 0);
        chk("R9 reset vsync", vsync, 0);
        chk("R9 reset de", de, 0);
        chk("R9 reset pix_ce", pix_ce, 0);
        chk("R9 reset frame_done", frame_done, 0);
        chk("R9 reset pclk", pclk, 0);

        // Table walk: R1 R2 R3 R4 R5 R6 R8 R11
        for (int i = 0; i < 5; i++) begin
            int d, h, v, w, l, hi;
            d = div_of(i); h = htot(i); v = vtot(i);
            w = 16 * (VEC[i][4] + 1); l = VEC[i][8] + 1;
            hi = (d + 1) / 2;
            restart(i, 1'b0, 1'b0);
            measure(VEC[i][9][0], VEC[i][10][0], clks, hsn, vsn, den, pcn, mx, my);
            measure(VEC[i][9][0], VEC[i][10][0], clks, hsn, vsn, den, pcn, mx, my);
            chk($sformatf("R1 R2 R3 R8 R11 frame clocks v%0d", i), clks, d * h * v);
            chk($sformatf("R2 R5 hsync active clocks v%0d", i), hsn, d * (VEC[i][1] + 1) * v);
            chk($sformatf("R3 R5 vsync active clocks v%0d", i), vsn, d * h * (VEC[i][5] + 1));
            chk($sformatf("R4 de clocks v%0d", i), den, d * w * l);
            chk($sformatf("R4 max pix_x v%0d", i), mx, w - 1);
            chk($sformatf("R4 max pix_y v%0d", i), my, l - 1);
            chk($sformatf("R6 pclk high clocks v%0d", i), pcn,
                (VEC[i][11] != 0) ? (d - hi) * h * v : hi * h * v);
        end

        // R1 pixel strobe spacing with divisor 5
        restart(3, 1'b0, 1'b0);
        while (!pix_ce) @(negedge clk);
        n = 0;
        do begin @(negedge clk); n++; end while (!pix_ce);
        chk("R1 pix_ce spacing", n, 5);

        // R7 late syncs on the falling pixel clock half
        restart(0, 1'b1, 1'b0);
        measure(1'b0, 1'b0, clks, hsn, vsn, den, pcn, mx, my);
        chk("R7 late hsync at frame start", hsync, 0);
        chk("R7 late vsync at frame start", vsync, 0);
        @(negedge clk);
        chk("R7 late hsync one clock on", hsync, 1);
        chk("R7 late vsync one clock on", vsync, 1);
        measure(1'b0, 1'b0, clks, hsn, vsn, den, pcn, mx, my);
        chk("R7 late hsync active clocks", hsn, 2 * 1 * 6);
        restart(0, 1'b1, 1'b1);
        measure(1'b0, 1'b0, clks, hsn, vsn, den, pcn, mx, my);
        chk("R7 rising-edge hsync at frame start", hsync, 1);

        // R9 disable mid-frame then restart
        restart(0, 1'b0, 1'b0);
        repeat (40) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R9 parked hsync", hsync, 0);
        chk("R9 parked de", de, 0);
        chk("R9 parked pix_ce", pix_ce, 0);
        chk("R9 parked pclk", pclk, 0);
        enable = 1'b1;
        #1;
        chk("R9 first hsync", hsync, 1);
        chk("R9 first vsync", vsync, 1);
        @(negedge clk);
        n = 1;
        while (!frame_done) begin @(negedge clk); n++; end
        chk("R9 clocks to first frame_done", n, 2 * 22 * 6);
        @(negedge clk);
        chk("R8 frame_done one clock wide", frame_done, 0);

        // R10 mid-frame write waits for the next frame
        restart(0, 1'b0, 1'b0);
        while (!frame_done) @(negedge clk);
        repeat (10) @(negedge clk);
        drive_cfg(0, 1'b0, 1'b0, 12'd5);
        n = 10;
        while (!frame_done) begin @(negedge clk); n++; end
        chk("R10 current frame unchanged", n, 2 * 22 * 6);
        measure(1'b0, 1'b0, clks, hsn, vsn, den, pcn, mx, my);
        chk("R10 next frame uses new hfp", clks, 2 * 25 * 6);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule